// File: doc/BRIEF.md
# Gated Master-Slave Timer Pair

Two up-counting timers run from one internal clock. The master timer compares its counter against a compare value and forms a reference waveform. That waveform can be routed out as a trigger. The slave timer selects that trigger as its input. In gated mode the slave's counter advances only while the trigger is high. While the trigger is low the slave holds its value. The gate never restarts the slave's prescaler or counter.

Each timer has the same set of controls:
- an enable bit;
- a self-clearing update-generation bit;
- a prescaler;
- an auto-reload value;
- a counter load port.

Software sets up the pair through a single-cycle register write port. A typical sequence is:
1. Reset both timers with the update bit.
2. Preload a start value into the slave counter.
3. Enable the slave in gated mode.
4. Start the master with the trigger routed out.

Each timer holds a run state machine with three states:
- **STOP**: the enable bit is clear.
- **WAIT**: the timer is enabled but its gate is low.
- **COUNT**: the timer is enabled and its gate is high.

The transitions are:
- **start**: STOP→COUNT (enable set, gate high).
- **arm**: STOP→WAIT (enable set, gate low).
- **open**: WAIT→COUNT (gate rises).
- **close**: COUNT→WAIT (gate falls).
- **halt**: WAIT→STOP and COUNT→STOP (enable cleared).

The state register samples the enable and the gate. The counter and prescaler advance only in COUNT. The master's gate is tied high.

Top module: `gated_timer_pair`

Register map. All fields are sampled on the write edge.

| Address | Contents |
|---|---|
| 0 | master control: bit 0 enable, bit 1 update, bits 6:4 trigger-output mode |
| 1 | slave control: bit 0 enable, bit 1 update, bits 6:4 trigger source, bits 10:8 slave mode |
| 2 | master prescale |
| 3 | slave prescale |
| 4 | master reload |
| 5 | slave reload |
| 6 | master compare |
| 7 | master counter load |
| 8 | slave counter load |

## Requirements
- R1: After reset both counters read 0, the compare value is 0, the reference output is low and the trigger output is low.
- R2: With a prescale field value P, an enabled and ungated timer advances once every P+1 clocks. P=2 gives one third of the clock rate. After a write that enables a stopped timer, the counter reads floor((k-1)/(P+1)) k edges later.
- R3: A counter equal to its reload value goes to 0 on its next advance.
- R4: Enable is bit 0 of the control word. After a write clears it, the counter advances on at most two more edges and then holds.
- R5: Re-enabling a stopped timer without an update resumes counting from the held value; the counter is not cleared.
- R6: Writing 1 to bit 1 of a control word clears that timer's counter and prescaler on the write edge. The bit is never stored.
- R7: A write to address 7 (master) or 8 (slave) loads the counter with the written value, for example 0xE7.
- R8: The reference output is high exactly while the master counter is below the compare value.
- R9: Trigger-output mode 3'b100 drives the reference onto the trigger output. Any other mode, including the reset value 3'b000, keeps the trigger output low.
- R10: Trigger source 3'b000 connects the master trigger output to the slave input. Any other code gives a low slave input.
- R11: Slave mode 3'b101 is gated: the slave advances only while its input is high, and holds its value while the input is low.
- R12: Any slave mode other than 3'b101 lets the slave count on its own enable alone, whatever the trigger.
- R13: Clearing the master enable freezes the master counter and the reference. When the frozen reference is low, a gated slave stops advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock shared by both timers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| m_count | output | 16 | Master counter value |
| s_count | output | 16 | Slave counter value |
| oc_ref | output | 1 | Master compare reference |
| trig_out | output | 1 | Master trigger output |

## Verification
A run state stuck in COUNT or STOP shows at the counter port within one prescale period. Either the counter keeps moving after the enable or gate has dropped, or it stays still while both are high. A gate that is mis-sampled breaks the 4-in-10 duty ratio of the slave against a 10-state master with compare 4, and a 100-cycle window exposes it. A prescaler that is not cleared, or not frozen, moves the first advance after a start by one or more clocks. The exact-cycle counter checks catch this on the first count.

// File: rtl/gtp_pkg.sv
package gtp_pkg;

    typedef enum logic [1:0] {
        ST_STOP,
        ST_WAIT,
        ST_COUNT
    } run_state_t;

    localparam logic [3:0] ADR_M_CTL = 4'd0;
    localparam logic [3:0] ADR_S_CTL = 4'd1;
    localparam logic [3:0] ADR_M_PSC = 4'd2;
    localparam logic [3:0] ADR_S_PSC = 4'd3;
    localparam logic [3:0] ADR_M_ARR = 4'd4;
    localparam logic [3:0] ADR_S_ARR = 4'd5;
    localparam logic [3:0] ADR_M_CMP = 4'd6;
    localparam logic [3:0] ADR_M_CNT = 4'd7;
    localparam logic [3:0] ADR_S_CNT = 4'd8;

    localparam logic [2:0] MMS_REF   = 3'b100;
    localparam logic [2:0] TS_MASTER = 3'b000;
    localparam logic [2:0] SMS_GATED = 3'b101;

endpackage

// File: rtl/gtp_regs.sv
module gtp_regs
    import gtp_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic          m_en,
    output logic          s_en,
    output logic          m_ug,
    output logic          s_ug,
    output logic [2:0]    mms,
    output logic [2:0]    ts,
    output logic [2:0]    sms,
    output logic [W-1:0]  m_psc,
    output logic [W-1:0]  s_psc,
    output logic [W-1:0]  m_arr,
    output logic [W-1:0]  s_arr,
    output logic [W-1:0]  cmp,
    output logic          m_cwr,
    output logic          s_cwr
);

    logic hit_m_ctl, hit_s_ctl;

    assign hit_m_ctl = wr_en && (wr_addr == AW'(ADR_M_CTL));
    assign hit_s_ctl = wr_en && (wr_addr == AW'(ADR_S_CTL));

    // Update bits are pulses taken straight from the write; nothing stores them.
    assign m_ug  = hit_m_ctl && wr_data[1];
    assign s_ug  = hit_s_ctl && wr_data[1];
    assign m_cwr = wr_en && (wr_addr == AW'(ADR_M_CNT));
    assign s_cwr = wr_en && (wr_addr == AW'(ADR_S_CNT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en  <= 1'b0;
            s_en  <= 1'b0;
            mms   <= 3'b000;
            ts    <= 3'b000;
            sms   <= 3'b000;
            m_psc <= '0;
            s_psc <= '0;
            m_arr <= '1;
            s_arr <= '1;
            cmp   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                AW'(ADR_M_CTL): begin
                    m_en <= wr_data[0];
                    mms  <= wr_data[6:4];
                end
                AW'(ADR_S_CTL): begin
                    s_en <= wr_data[0];
                    ts   <= wr_data[6:4];
                    sms  <= wr_data[10:8];
                end
                AW'(ADR_M_PSC): m_psc <= wr_data;
                AW'(ADR_S_PSC): s_psc <= wr_data;
                AW'(ADR_M_ARR): m_arr <= wr_data;
                AW'(ADR_S_ARR): s_arr <= wr_data;
                AW'(ADR_M_CMP): cmp   <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gtp_timer_core.sv
module gtp_timer_core
    import gtp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         gate,
    input  logic         ug,
    input  logic         cwr,
    input  logic [W-1:0] cdata,
    input  logic [W-1:0] psc,
    input  logic [W-1:0] arr,
    output logic [W-1:0] cnt
);

    run_state_t state, state_nxt;
    logic [W-1:0] pcnt;
    logic         counting, tick;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_nxt;
    end

    // Next-state logic: start, arm, open, close and halt transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STOP:  if (en) state_nxt = gate ? ST_COUNT : ST_WAIT;
            ST_WAIT:  if (!en) state_nxt = ST_STOP;
                      else if (gate) state_nxt = ST_COUNT;
            ST_COUNT: if (!en) state_nxt = ST_STOP;
                      else if (!gate) state_nxt = ST_WAIT;
            default:  state_nxt = ST_STOP;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        counting = (state == ST_COUNT);
        tick     = counting && (pcnt >= psc);
    end

    // Prescaler and counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pcnt <= '0;
        end else if (ug) begin
            cnt  <= '0;
            pcnt <= '0;
        end else if (cwr) begin
            cnt  <= cdata;
        end else if (counting) begin
            if (tick) begin
                pcnt <= '0;
                cnt  <= (cnt == arr) ? '0 : cnt + 1'b1;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    // R11 / R4: outside COUNT the counter holds unless it is reloaded.
    a_r11_hold_outside_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !ug && !cwr) |=> $stable(cnt));

    // R3: an advance from the reload value lands on 0.
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == arr && !ug && !cwr) |=> (cnt == '0));

    // R6: the update pulse clears the counter and the prescaler.
    a_r6_update_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (cnt == '0 && pcnt == '0));

    // R7: the load port writes the counter.
    a_r7_counter_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && !ug) |=> (cnt == $past(cdata)));

    // R4: a cleared enable reaches STOP on the next edge.
    a_r4_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_STOP));

endmodule

// File: rtl/gtp_trigger.sv
module gtp_trigger
    import gtp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] m_cnt,
    input  logic [W-1:0] cmp,
    input  logic [2:0]   mms,
    input  logic [2:0]   ts,
    input  logic [2:0]   sms,
    output logic         oc_ref,
    output logic         trig_out,
    output logic         s_gate
);

    logic s_trig_in;

    always_comb begin
        // Reference is high while the master counter is below the compare value.
        oc_ref    = (m_cnt < cmp);
        trig_out  = (mms == MMS_REF) ? oc_ref : 1'b0;
        s_trig_in = (ts == TS_MASTER) ? trig_out : 1'b0;
        // In gated mode the input only qualifies the enable; otherwise it is ignored.
        s_gate    = (sms == SMS_GATED) ? s_trig_in : 1'b1;
    end

endmodule

// File: rtl/gated_timer_pair.sv
module gated_timer_pair
    import gtp_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  m_count,
    output logic [W-1:0]  s_count,
    output logic          oc_ref,
    output logic          trig_out
);

    logic         m_en, s_en, m_ug, s_ug, m_cwr, s_cwr, s_gate;
    logic [2:0]   mms, ts, sms;
    logic [W-1:0] m_psc, s_psc, m_arr, s_arr, cmp;

    gtp_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .m_en(m_en), .s_en(s_en), .m_ug(m_ug), .s_ug(s_ug),
        .mms(mms), .ts(ts), .sms(sms),
        .m_psc(m_psc), .s_psc(s_psc), .m_arr(m_arr), .s_arr(s_arr), .cmp(cmp),
        .m_cwr(m_cwr), .s_cwr(s_cwr)
    );

    gtp_timer_core #(.W(W)) u_master (
        .clk(clk), .rst_n(rst_n), .en(m_en), .gate(1'b1), .ug(m_ug), .cwr(m_cwr),
        .cdata(wr_data), .psc(m_psc), .arr(m_arr), .cnt(m_count)
    );

    gtp_trigger #(.W(W)) u_trig (
        .m_cnt(m_count), .cmp(cmp), .mms(mms), .ts(ts), .sms(sms),
        .oc_ref(oc_ref), .trig_out(trig_out), .s_gate(s_gate)
    );

    gtp_timer_core #(.W(W)) u_slave (
        .clk(clk), .rst_n(rst_n), .en(s_en), .gate(s_gate), .ug(s_ug), .cwr(s_cwr),
        .cdata(wr_data), .psc(s_psc), .arr(s_arr), .cnt(s_count)
    );

    // R9: any trigger-output mode other than the reference mode keeps the trigger low.
    a_r9_trigger_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mms != MMS_REF) |-> !trig_out);

    // R13: a master that is not enabled for two edges keeps its counter frozen.
    a_r13_master_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_en && !$past(m_en) && !m_ug && !m_cwr) |=> $stable(m_count));

endmodule

// File: tb/gated_timer_pair_bench.sv
module gated_timer_pair_bench;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  m_count, s_count;
    logic          oc_ref, trig_out;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    gated_timer_pair #(.W(W), .AW(4)) u_gated_timer_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .m_count(m_count), .s_count(s_count), .oc_ref(oc_ref), .trig_out(trig_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 master count", int'(m_count), 0);
        chk("R1 slave count", int'(s_count), 0);
        chk("R1 reference", int'(oc_ref), 0);
        chk("R1 trigger", int'(trig_out), 0);
    endtask

    task automatic t_prescale;
        wr(4'd2, 16'd2);
        wr(4'd4, 16'd1000);
        wr(4'd0, 16'h0003);
        idle(31);
        chk("R2 divide-by-3 at k=31", int'(m_count), 10);
        idle(1);
        chk("R2 hold between ticks", int'(m_count), 10);
        idle(2);
        chk("R2 next tick at k=34", int'(m_count), 11);
        wr(4'd0, 16'h0000);
        idle(3);
    endtask

    task automatic t_wrap;
        wr(4'd2, 16'd0);
        wr(4'd4, 16'd5);
        wr(4'd0, 16'h0003);
        idle(6);
        chk("R3 at reload", int'(m_count), 5);
        idle(1);
        chk("R3 wrap to 0", int'(m_count), 0);
        wr(4'd0, 16'h0000);
        idle(3);
    endtask

    task automatic t_freeze_resume;
        int v, f;
        wr(4'd4, 16'd1000);
        wr(4'd0, 16'h0003);
        idle(20);
        v = int'(m_count);
        wr(4'd0, 16'h0000);
        idle(10);
        f = int'(m_count);
        chk("R4 frozen after disable", f, v + 2);
        wr(4'd0, 16'h0001);
        idle(5);
        chk("R5 resume from held value", int'(m_count), f + 4);
        wr(4'd0, 16'h0000);
        idle(3);
    endtask

    task automatic t_gating;
        int v;
        wr(4'd1, 16'h0000);
        idle(3);
        wr(4'd4, 16'd9);
        wr(4'd6, 16'd4);
        wr(4'd3, 16'd0);
        wr(4'd5, 16'hFFFF);
        wr(4'd1, 16'h0002);
        chk("R6 slave update clears", int'(s_count), 0);
        wr(4'd8, 16'h00E7);
        chk("R7 slave counter load", int'(s_count), 'hE7);
        wr(4'd1, 16'h0501);
        idle(20);
        chk("R9 mode 000 keeps trigger low", int'(trig_out), 0);
        chk("R11 gated slave holds with low input", int'(s_count), 'hE7);
        wr(4'd0, 16'h0043);
        idle(30);
        for (int i = 0; i < 10; i++) begin
            chk("R8 reference vs compare", int'(oc_ref), int'(m_count < 16'd4));
            chk("R9 trigger follows reference", int'(trig_out), int'(oc_ref));
            idle(1);
        end
        v = int'(s_count);
        idle(100);
        chk("R11 gated slave 40 of 100", int'(s_count) - v, 40);
        wr(4'd1, 16'h0511);
        idle(3);
        v = int'(s_count);
        idle(30);
        chk("R10 other trigger source holds slave", int'(s_count), v);
        wr(4'd1, 16'h0011);
        idle(5);
        v = int'(s_count);
        idle(20);
        chk("R12 non-gated mode free runs", int'(s_count) - v, 20);
        wr(4'd1, 16'h0501);
        idle(3);
        while (m_count != 16'd6) @(negedge clk);
        wr(4'd0, 16'h0040);
        idle(3);
        chk("R13 master frozen", int'(m_count), 8);
        chk("R13 frozen trigger low", int'(trig_out), 0);
        v = int'(s_count);
        idle(20);
        chk("R13 slave stopped", int'(s_count), v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_prescale;
        t_wrap;
        t_freeze_resume;
        t_gating;
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule